// File: doc/BRIEF.md
# Serial EEPROM Image Cache and Checksum Controller

This block sits between a host and an engine that reads and writes single 16-bit words of a 64-word serial configuration EEPROM. It keeps a copy of the whole image in local registers. It answers host lookups from that copy, either as one word or as a 32-bit assembly number built from two words. The copy counts as usable only when two tests pass. First, the 16-bit wraparound sum of all 64 words must equal 0xBABA. Second, bits 15:14 of the control word at address 0x0A must hold 2'b01.

When a lookup finds the copy unusable, the block reloads the full image through the engine and then answers. The host can also order a reload, write a single word, or run a checksum repair. The repair sums words 0 to 62 and writes the missing amount into word 63, so that the total becomes 0xBABA again.

Any write through the block clears the cached control word, and a reload that ends with a bad sum does the same. In both cases the next lookup goes back to the device.

Top module: `eeprom_image_cache`

## Requirements
- R1: After reset, `status` is 0 (idle), `req_ready` is 1, and `eng_req`, `resp_valid` and `done` are 0.
- R2: A reload issues 64 engine reads (`eng_we`=0) to addresses 0,1,...,63 in that order and stores each returned word in the cache.
- R3: The cache is valid only if the 16-bit wraparound sum of the 64 words equals 0xBABA and bits 15:14 of word 0x0A equal 2'b01. The `status` codes are 0 idle, 1 loading, 2 valid and 3 invalid. While a reload runs, `status` is 1; afterwards it is 2 or 3.
- R4: A reload with a bad sum clears the cached control word, sets `status` to 3 and makes a word lookup return 0. The following lookup reloads again.
- R5: A reload with a good sum but a wrong signature sets `status` to 3 and makes lookups return 0.
- R6: On a valid cache, a word lookup (`req_op`=1) makes no engine access. `resp_valid` is high in the cycle after acceptance, and `resp_data` is {16'h0, word}.
- R7: A lookup on an invalid cache first runs a full reload and then answers from the new contents.
- R8: A word lookup with `req_index` of 64 or more returns 0 and makes no engine access.
- R9: An assembly-number lookup (`req_op`=2) returns {word 0x09, word 0x08}, or 0 when the image is invalid.
- R10: A checksum update (`req_op`=4) reads words 0 to 62 in order. It then issues one engine write of (0xBABA − sum) mod 2^16 to address 63 and ends with a `done` pulse.
- R11: A word write (`req_op`=3) writes `req_wdata` to address `req_index[5:0]`. After any write, whether a word write or a checksum update, `status` becomes 3 and the next lookup reloads.
- R12: `done` is a one-cycle pulse at the end of every reload and every checksum update. `eng_req`, `eng_addr` and `eng_we` stay steady until `eng_ack`.
- R13: A reload command (`req_op`=0) rereads the full image even when the cache is already valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_op | input | 3 | 0 reload, 1 word lookup, 2 assembly number, 3 word write, 4 checksum update |
| req_index | input | 8 | Word index for lookup and write |
| req_wdata | input | 16 | Data for a word write |
| resp_valid | output | 1 | Lookup answer strobe |
| resp_data | output | 32 | Lookup answer |
| done | output | 1 | End of reload or checksum update |
| status | output | 2 | 0 idle, 1 loading, 2 valid, 3 invalid |
| eng_req | output | 1 | Word request to the serial engine |
| eng_we | output | 1 | 1 write, 0 read |
| eng_addr | output | 6 | Word address |
| eng_wdata | output | 16 | Word to write |
| eng_ack | input | 1 | Engine completion, one cycle |
| eng_rdata | input | 16 | Word read, valid with `eng_ack` |

## Verification
The hardest case to reach from the ports is an image whose sum is correct but whose signature field is wrong, because only that case isolates the second validity test. The bench builds such images arithmetically: it picks the control word first and then computes word 63 so that the total is exactly 0xBABA. A second hard path is the chain of write, failed reload, second reload, repair and good reload. The bench drives that chain against an engine model whose latency changes between phases, and it counts engine reads and writes to show where the cache answered without the device.

// File: rtl/eic_pkg.sv
package eic_pkg;
  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_WORD   = 3'd1,
    OP_ASM    = 3'd2,
    OP_WRITE  = 3'd3,
    OP_UPDATE = 3'd4
  } eic_op_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_LOADING = 2'd1,
    ST_VALID   = 2'd2,
    ST_INVALID = 2'd3
  } eic_stat_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LD_RD,
    S_LD_CHK,
    S_LK_RESP,
    S_UP_RD,
    S_UP_WR,
    S_UP_FIN,
    S_WR
  } eic_state_e;
endpackage

// File: rtl/eic_sum_acc.sv
module eic_sum_acc #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add_en,
  input  logic [DW-1:0] add_val,
  output logic [DW-1:0] sum
);
  logic [DW-1:0] sum_q, sum_d;

  always_comb begin
    sum_d = sum_q;
    if (clr)         sum_d = '0;
    else if (add_en) sum_d = sum_q + add_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               sum_q <= '0;
    else if (clr || add_en)   sum_q <= sum_d;
  end

  assign sum = sum_q;
endmodule

// File: rtl/eic_image_store.sv
module eic_image_store #(
  parameter int WORDS     = 64,
  parameter int DW        = 16,
  parameter int CTRL_ADDR = 10,
  parameter int ASM_LO    = 8,
  parameter int ASM_HI    = 9,
  localparam int AW       = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          inval,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] ctrl_word,
  output logic [DW-1:0] asm_lo,
  output logic [DW-1:0] asm_hi
);
  logic [DW-1:0] words [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic          hit;
    logic [DW-1:0] q;
    assign hit = wr_en && (wr_addr == AW'(g));
    if (g == CTRL_ADDR) begin : g_ctrl
      // the control word decides validity, so it alone has a reset and a clear
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (inval) q <= '0;
        else if (hit)   q <= wr_data;
      end
    end else begin : g_data
      always_ff @(posedge clk) begin
        if (hit) q <= wr_data;
      end
    end
    assign words[g] = q;
  end

  assign rd_data   = words[rd_addr];
  assign ctrl_word = words[CTRL_ADDR];
  assign asm_lo    = words[ASM_LO];
  assign asm_hi    = words[ASM_HI];
endmodule

// File: rtl/eic_seq.sv
module eic_seq
  import eic_pkg::*;
#(
  parameter int          WORDS  = 64,
  parameter int          DW     = 16,
  parameter int          IDXW   = 8,
  parameter logic [15:0] TARGET = 16'hBABA,
  localparam int         AW     = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [2:0]      req_op,
  input  logic [IDXW-1:0] req_index,
  input  logic [DW-1:0]   req_wdata,
  input  logic            sig_ok,
  input  logic [DW-1:0]   sum,
  input  logic            eng_ack,
  output logic            idle,
  output logic            eng_req,
  output logic            eng_we,
  output logic [AW-1:0]   eng_addr,
  output logic [DW-1:0]   eng_wdata,
  output logic            acc_clr,
  output logic            acc_add,
  output logic            st_wr,
  output logic            inval,
  output logic            resp_valid,
  output logic            lk_asm,
  output logic            lk_zero,
  output logic [AW-1:0]   lk_idx,
  output logic            done,
  output logic [1:0]      status
);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  eic_state_e    state_q, state_d;
  logic [AW-1:0] idx_q, idx_d, lidx_q, lidx_d;
  logic          pend_q, pend_d, asm_q, asm_d, zero_q, zero_d;
  logic [DW-1:0] wdat_q, wdat_d;
  eic_stat_e     stat_q, stat_d;
  logic          sum_ok;

  assign sum_ok = (sum == DW'(TARGET));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    lidx_d  = lidx_q;
    pend_d  = pend_q;
    asm_d   = asm_q;
    zero_d  = zero_q;
    wdat_d  = wdat_q;
    stat_d  = stat_q;
    acc_clr = 1'b0;
    acc_add = 1'b0;
    st_wr   = 1'b0;
    inval   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          idx_d   = '0;
          acc_clr = 1'b1;
          pend_d  = 1'b0;
          asm_d   = 1'b0;
          zero_d  = 1'b0;
          lidx_d  = req_index[AW-1:0];
          case (req_op)
            OP_LOAD: begin
              state_d = S_LD_RD;
              stat_d  = ST_LOADING;
            end
            OP_WORD, OP_ASM: begin
              pend_d = 1'b1;
              asm_d  = (req_op == OP_ASM);
              if (req_op == OP_WORD && int'(req_index) >= WORDS) begin
                zero_d  = 1'b1;
                state_d = S_LK_RESP;
              end else if (sig_ok) begin
                state_d = S_LK_RESP;
              end else begin
                state_d = S_LD_RD;
                stat_d  = ST_LOADING;
              end
            end
            OP_WRITE: begin
              wdat_d  = req_wdata;
              state_d = S_WR;
            end
            OP_UPDATE: state_d = S_UP_RD;
            default:   state_d = S_IDLE;
          endcase
        end
      end
      S_LD_RD: begin
        if (eng_ack) begin
          st_wr   = 1'b1;
          acc_add = 1'b1;
          if (idx_q == LAST) state_d = S_LD_CHK;
          else               idx_d   = idx_q + 1'b1;
        end
      end
      S_LD_CHK: begin
        inval   = !sum_ok;
        stat_d  = (sum_ok && sig_ok) ? ST_VALID : ST_INVALID;
        state_d = pend_q ? S_LK_RESP : S_IDLE;
      end
      S_LK_RESP: state_d = S_IDLE;
      S_UP_RD: begin
        if (eng_ack) begin
          acc_add = 1'b1;
          if (idx_q == LAST - 1'b1) state_d = S_UP_WR;
          else                      idx_d   = idx_q + 1'b1;
        end
      end
      S_UP_WR: begin
        if (eng_ack) begin
          inval   = 1'b1;
          stat_d  = ST_INVALID;
          state_d = S_UP_FIN;
        end
      end
      S_UP_FIN: state_d = S_IDLE;
      S_WR: begin
        if (eng_ack) begin
          inval   = 1'b1;
          stat_d  = ST_INVALID;
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      lidx_q  <= '0;
      pend_q  <= 1'b0;
      asm_q   <= 1'b0;
      zero_q  <= 1'b0;
      wdat_q  <= '0;
      stat_q  <= ST_IDLE;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      lidx_q  <= lidx_d;
      pend_q  <= pend_d;
      asm_q   <= asm_d;
      zero_q  <= zero_d;
      wdat_q  <= wdat_d;
      stat_q  <= stat_d;
    end
  end

  assign idle       = (state_q == S_IDLE);
  assign eng_req    = (state_q == S_LD_RD) || (state_q == S_UP_RD) ||
                      (state_q == S_UP_WR) || (state_q == S_WR);
  assign eng_we     = (state_q == S_UP_WR) || (state_q == S_WR);
  assign eng_addr   = (state_q == S_WR)    ? lidx_q :
                      (state_q == S_UP_WR) ? LAST   : idx_q;
  assign eng_wdata  = (state_q == S_WR) ? wdat_q : (DW'(TARGET) - sum);
  assign resp_valid = (state_q == S_LK_RESP);
  assign done       = (state_q == S_LD_CHK) || (state_q == S_UP_FIN);
  assign lk_asm     = asm_q;
  assign lk_zero    = zero_q;
  assign lk_idx     = lidx_q;
  assign status     = stat_q;
endmodule

// File: rtl/eeprom_image_cache.sv
module eeprom_image_cache #(
  parameter int          WORDS     = 64,
  parameter int          DW        = 16,
  parameter int          IDXW      = 8,
  parameter logic [15:0] TARGET    = 16'hBABA,
  parameter int          CTRL_ADDR = 10,
  parameter int          ASM_LO    = 8,
  parameter int          ASM_HI    = 9,
  parameter logic [15:0] SIG_MASK  = 16'hC000,
  parameter logic [15:0] SIG_CODE  = 16'h4000,
  localparam int         AW        = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_op,
  input  logic [IDXW-1:0] req_index,
  input  logic [DW-1:0]   req_wdata,
  output logic            resp_valid,
  output logic [2*DW-1:0] resp_data,
  output logic            done,
  output logic [1:0]      status,
  output logic            eng_req,
  output logic            eng_we,
  output logic [AW-1:0]   eng_addr,
  output logic [DW-1:0]   eng_wdata,
  input  logic            eng_ack,
  input  logic [DW-1:0]   eng_rdata
);
  // reset asserts at once and leaves on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic          idle, acc_clr, acc_add, st_wr, inval, sig_ok;
  logic          lk_asm, lk_zero;
  logic [AW-1:0] lk_idx;
  logic [DW-1:0] sum, rd_data, ctrl_word, asm_lo, asm_hi;

  eic_sum_acc #(.DW(DW)) i_acc (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (acc_clr),
    .add_en (acc_add),
    .add_val(eng_rdata),
    .sum    (sum)
  );

  eic_image_store #(
    .WORDS(WORDS), .DW(DW), .CTRL_ADDR(CTRL_ADDR),
    .ASM_LO(ASM_LO), .ASM_HI(ASM_HI)
  ) i_store (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (st_wr),
    .wr_addr  (eng_addr),
    .wr_data  (eng_rdata),
    .inval    (inval),
    .rd_addr  (lk_idx),
    .rd_data  (rd_data),
    .ctrl_word(ctrl_word),
    .asm_lo   (asm_lo),
    .asm_hi   (asm_hi)
  );

  assign sig_ok = ((ctrl_word & DW'(SIG_MASK)) == DW'(SIG_CODE));

  eic_seq #(
    .WORDS(WORDS), .DW(DW), .IDXW(IDXW), .TARGET(TARGET)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid && req_ready),
    .req_op    (req_op),
    .req_index (req_index),
    .req_wdata (req_wdata),
    .sig_ok    (sig_ok),
    .sum       (sum),
    .eng_ack   (eng_ack),
    .idle      (idle),
    .eng_req   (eng_req),
    .eng_we    (eng_we),
    .eng_addr  (eng_addr),
    .eng_wdata (eng_wdata),
    .acc_clr   (acc_clr),
    .acc_add   (acc_add),
    .st_wr     (st_wr),
    .inval     (inval),
    .resp_valid(resp_valid),
    .lk_asm    (lk_asm),
    .lk_zero   (lk_zero),
    .lk_idx    (lk_idx),
    .done      (done),
    .status    (status)
  );

  assign req_ready = idle && rst_int_n;

  always_comb begin
    if (lk_zero || !sig_ok) resp_data = '0;
    else if (lk_asm)        resp_data = {asm_hi, asm_lo};
    else                    resp_data = {{DW{1'b0}}, rd_data};
  end
endmodule

// File: rtl/eeprom_image_cache_chk.sv
module eeprom_image_cache_chk #(
  parameter int DW = 16,
  parameter int IDXW = 8,
  parameter int AW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [2:0]      req_op,
  input logic [IDXW-1:0] req_index,
  input logic [DW-1:0]   req_wdata,
  input logic            resp_valid,
  input logic [2*DW-1:0] resp_data,
  input logic            done,
  input logic [1:0]      status,
  input logic            eng_req,
  input logic            eng_we,
  input logic [AW-1:0]   eng_addr,
  input logic [DW-1:0]   eng_wdata,
  input logic            eng_ack,
  input logic [DW-1:0]   eng_rdata
);
  // R12
  eng_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_ack) |=> (eng_req && $stable(eng_addr) && $stable(eng_we)));

  // R3
  done_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (status == 2'd2 || status == 2'd3));

  // R5
  invalid_resp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && status == 2'd3) |-> (resp_data == '0));

  // R11
  write_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 3'd3) |=> (eng_req && eng_we));

  // R8
  range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 3'd1 && req_index >= 8'd64) |=> (resp_valid && resp_data == '0 && !eng_req));
endmodule

bind eeprom_image_cache eeprom_image_cache_chk #(.DW(DW), .IDXW(IDXW), .AW(AW)) i_chk (.*);

// File: tb/test_eeprom_image_cache.sv
module test_eeprom_image_cache;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [2:0]  req_op;
  logic [7:0]  req_index;
  logic [15:0] req_wdata;
  logic        resp_valid, done;
  logic [31:0] resp_data;
  logic [1:0]  status;
  logic        eng_req, eng_we, eng_ack;
  logic [5:0]  eng_addr;
  logic [15:0] eng_wdata, eng_rdata;

  always #10 clk = ~clk;

  eeprom_image_cache i_eeprom_image_cache (.*);

  logic [15:0] mem [N];
  int lat, cnt, nrd, nwr, ord_err, exp_addr;
  int nchk, nerr;
  bit finished;

  // engine model: answers after lat+1 cycles with a one-cycle ack
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_ack <= 1'b0; cnt <= 0; eng_rdata <= '0;
    end else if (eng_ack) begin
      eng_ack <= 1'b0; cnt <= 0;
    end else if (eng_req) begin
      if (cnt >= lat) begin
        eng_ack <= 1'b1; cnt <= 0;
        if (eng_we) begin
          mem[eng_addr] = eng_wdata;
          nwr = nwr + 1;
        end else begin
          eng_rdata <= mem[eng_addr];
          if (int'(eng_addr) != exp_addr) ord_err = ord_err + 1;
          exp_addr = exp_addr + 1;
          nrd = nrd + 1;
        end
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] sum_to(int n);
    logic [15:0] s = '0;
    for (int i = 0; i < n; i++) s = s + mem[i];
    return s;
  endfunction

  function automatic void build(logic [15:0] seed, logic [15:0] sig, bit good);
    for (int i = 0; i < N; i++) mem[i] = 16'(i * 16'h3C5B) ^ seed ^ 16'(i << 11);
    mem[10] = sig;
    mem[63] = 16'hBABA - sum_to(63) + (good ? 16'h0 : 16'h1);
  endfunction

  task automatic send(int op, int idx, logic [15:0] wd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_addr = 0;
    req_valid = 1'b1; req_op = 3'(op); req_index = 8'(idx); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic lookup(int op, int idx, output logic [31:0] d, output int lag);
    send(op, idx, 16'h0);
    lag = 0;
    while (!resp_valid) begin @(negedge clk); lag++; end
    d = resp_data;
  endtask

  task automatic wait_done(string tag);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk({tag, " done one cycle"}, 32'(done), 32'd0);
  endtask

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int lag, r0, w0;
    logic [15:0] xw;
    nchk = 0; nerr = 0; nrd = 0; nwr = 0; ord_err = 0; exp_addr = 0; lat = 1;
    req_valid = 0; req_op = 0; req_index = 0; req_wdata = 0;
    rst_n = 1'b0;
    build(16'hF00D, 16'h4ABC, 1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 status", 32'(status), 32'd0);
    chk("R1 ready", 32'(req_ready), 32'd1);
    chk("R1 eng_req", 32'(eng_req), 32'd0);
    chk("R1 resp/done", {30'd0, resp_valid, done}, 32'd0);

    // R7 R2 R3: first lookup reloads
    r0 = nrd;
    lookup(1, 5, d, lag);
    chk("R7 word after reload", d, {16'h0, mem[5]});
    chk("R2 reads", 32'(nrd - r0), 32'd64);
    chk("R2 order", 32'(ord_err), 32'd0);
    @(negedge clk);
    chk("R3 valid status", 32'(status), 32'd2);

    // R6: sweep every index from the cache
    r0 = nrd;
    for (int i = 0; i < N; i++) begin
      lookup(1, i, d, lag);
      chk("R6 cached word", d, {16'h0, mem[i]});
      chk("R6 latency", 32'(lag), 32'd0);
    end
    chk("R6 no engine reads", 32'(nrd - r0), 32'd0);

    // R8
    for (int k = 0; k < 3; k++) begin
      int ix;
      ix = (k == 0) ? 64 : (k == 1) ? 100 : 255;
      lookup(1, ix, d, lag);
      chk("R8 out of range", d, 32'd0);
    end
    chk("R8 no engine reads", 32'(nrd - r0), 32'd0);

    // R9
    lookup(2, 0, d, lag);
    chk("R9 assembly number", d, {mem[9], mem[8]});

    // R13 R12 R3
    lat = 0; r0 = nrd;
    send(0, 0, 16'h0);
    chk("R3 loading status", 32'(status), 32'd1);
    wait_done("R12 load");
    chk("R13 reload reads", 32'(nrd - r0), 32'd64);
    chk("R3 status after reload", 32'(status), 32'd2);

    // R11 word write, then R4 failed reloads
    lat = 2; w0 = nwr;
    xw = mem[20] ^ 16'h1234;
    send(3, 20, xw);
    wait_idle();
    chk("R11 engine write", 32'(nwr - w0), 32'd1);
    chk("R11 written word", 32'(mem[20]), 32'(xw));
    chk("R11 status", 32'(status), 32'd3);
    r0 = nrd;
    lookup(1, 20, d, lag);
    chk("R4 bad sum lookup", d, 32'd0);
    chk("R4 reload after write", 32'(nrd - r0), 32'd64);
    @(negedge clk);
    chk("R4 status", 32'(status), 32'd3);
    r0 = nrd;
    lookup(1, 3, d, lag);
    chk("R4 reload again", 32'(nrd - r0), 32'd64);
    lookup(2, 0, d, lag);
    chk("R9 invalid assembly", d, 32'd0);

    // R10 checksum update
    lat = 3; r0 = nrd; w0 = nwr;
    send(4, 0, 16'h0);
    wait_done("R10 update");
    chk("R10 reads", 32'(nrd - r0), 32'd63);
    chk("R10 order", 32'(ord_err), 32'd0);
    chk("R10 write", 32'(nwr - w0), 32'd1);
    chk("R10 word 63", 32'(mem[63]), 32'(16'hBABA - sum_to(63)));
    chk("R11 status after update", 32'(status), 32'd3);
    r0 = nrd;
    lookup(1, 20, d, lag);
    chk("R11 reload after update", 32'(nrd - r0), 32'd64);
    chk("R10 repaired image", d, {16'h0, xw});

    // R5 good sum, bad signature
    for (int s = 0; s < 3; s++) begin
      logic [15:0] sg;
      sg = (s == 0) ? 16'h8ABC : (s == 1) ? 16'hC123 : 16'h0FFF;
      build(16'h1357 + 16'(s), sg, 1'b1);
      lat = s;
      send(0, 0, 16'h0);
      wait_done("R5 load");
      chk("R5 status bad signature", 32'(status), 32'd3);
      lookup(1, 10, d, lag);
      chk("R5 lookup zero", d, 32'd0);
    end

    // R3 mask: low bits of the control word are free
    build(16'hFFEE, 16'h7FFF, 1'b1);
    lat = 1;
    send(0, 0, 16'h0);
    wait_done("R3 load");
    chk("R3 masked signature valid", 32'(status), 32'd2);
    lookup(1, 10, d, lag);
    chk("R3 control word", d, 32'h7FFF);
    lookup(2, 0, d, lag);
    chk("R9 assembly number 2", d, {mem[9], mem[8]});

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule